// File: doc/BRIEF.md
# Chained Dual-Channel Serial DAC Host Controller

This block is a host-side master that updates a chain of serially cascaded dual-channel 12-bit converters. The devices share one serial clock line and one active-low select/load strobe. Each device passes the bits it shifts out on to the data input of the next device. On a one-cycle start request the block captures a code pair for every device and serialises the whole chain's stream on one data line. It then raises the strobe so that every device loads its new pair at the same moment, and pulses done.

The serial waveform is timed from the system clock. The limits are given as nanosecond parameters together with the system clock period. Each one becomes a whole number of system cycles, rounded up and never less than one. The limits are: the data setup before a clock rise, the clock high and low times, the gap from the strobe falling to the first rise, the gap from the last rise to the strobe rising, and the strobe high pulse. The stream is ordered so that the device at the far end of the chain receives its bits first.

Top module: `dacchain_host`

## Requirements
- R1: During and after reset, before any start: strobe_n is 1, sclk is 0, busy is 0 and done is 0.
- R2: Each transaction produces exactly NDEV*24 sclk rising edges. The bits go out device by device, from device NDEV-1 (far end) to device 0 (nearest the host). For each device the stream carries 12 bits of channel A and then 12 bits of channel B, each most significant bit first. Device d's codes are codes_a[d*12 +: 12] and codes_b[d*12 +: 12].
- R3: After the strobe rises, a chain of shift-and-load devices holds, in device d, the A and B codes supplied for device d at start.
- R4: sclk is low whenever strobe_n falls, and it is low in the cycle before.
- R5: sdin changes only while sclk is low. It holds the same value for the whole high phase, including the cycle in which sclk rises.
- R6: Every sclk high phase lasts HIGH cycles, and every low phase between two rises lasts LOW cycles. LOW is the larger of the low time and the setup time, in cycles. With the defaults (8 ns clock, 40 ns limits) both HIGH and LOW are 5.
- R7: From strobe_n falling to the first sclk rise there are LEAD cycles, the larger of the select-to-clock gap and the setup time. The default is 5.
- R8: After the last sclk high phase, sclk stays low for TAIL cycles before strobe_n rises (default 5). The time from the last rise to the strobe rise is therefore HIGH+TAIL cycles.
- R9: strobe_n stays high for LOAD cycles (default 7, from 50 ns) before done is pulsed, and sclk never rises while strobe_n is high.
- R10: Let S = LEAD + NDEV*24*HIGH + (NDEV*24-1)*LOW + TAIL + LOAD. done is high for exactly one cycle, S+1 cycles after the cycle in which start was sampled (733 with the defaults). busy is high from the cycle after start through the cycle before done, and low while done is high.
- R11: A start request, or a change on codes_a or codes_b, while busy is high has no effect. The ongoing transaction delivers the captured codes, no further strobe fall follows, and only one done pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle transaction request, taken only while idle |
| codes_a | input | NDEV*CODE_W | Channel A codes, device d in slice d |
| codes_b | input | NDEV*CODE_W | Channel B codes, device d in slice d |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| sclk | output | 1 | Serial clock to all devices |
| sdin | output | 1 | Serial data to the first device in the chain |
| strobe_n | output | 1 | Shared active-low select; its rising edge loads every device |

## Verification
Each serial result falls at a fixed cycle offset from the sampled start. The strobe falls one cycle later and the first sclk rise comes LEAD cycles after that. The phases then alternate in HIGH and LOW cycles, TAIL cycles pass before the strobe rises, and done follows LOAD cycles later, S+1 cycles after start (733 by default). The bench samples every output on the falling system clock edge and measures each run of sclk and strobe_n levels in whole cycles. It compares these lengths with the expected phase counts and compares the done cycle index with the start cycle plus S+1. A model of the device chain is clocked by the observed sclk rises and strobe rise, so the delivered codes are checked only after the load edge.

// File: rtl/dacchain_pkg.sv
package dacchain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_HIGH = 3'd2,
    ST_LOW  = 3'd3,
    ST_TAIL = 3'd4,
    ST_LOAD = 3'd5
  } phase_e;

  // Whole system cycles covering a time in ns, never below one.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/frame_pack.sv
module frame_pack #(
  parameter int NDEV   = 3,
  parameter int CODE_W = 12,
  localparam int SLOT_W = 2 * CODE_W,
  localparam int LEN    = NDEV * SLOT_W
) (
  input  logic [NDEV*CODE_W-1:0] codes_a,
  input  logic [NDEV*CODE_W-1:0] codes_b,
  output logic [LEN-1:0]         frame
);

  // The highest slot leaves first, so the far-end device owns the top slot.
  for (genvar d = 0; d < NDEV; d++) begin : g_slot
    assign frame[d*SLOT_W +: SLOT_W] = {codes_a[d*CODE_W +: CODE_W],
                                        codes_b[d*CODE_W +: CODE_W]};
  end

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
  parameter int LEN = 72,
  localparam int BW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [LEN-1:0] frame,
  input  logic           shift,
  output logic           bit_out,
  output logic           last
);

  logic [LEN-1:0] sr_q, sr_d;
  logic [BW-1:0]  left_q, left_d;

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    if (load) begin
      sr_d   = frame;
      left_d = BW'(LEN - 1);
    end else if (shift) begin
      sr_d   = {sr_q[LEN-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
    end
  end

  assign bit_out = sr_q[LEN-1];
  assign last    = (left_q == '0);

  // R2: the sequencer never advances past the final bit of the stream
  assert_no_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last);

endmodule

// File: rtl/dacchain_host.sv
module dacchain_host
  import dacchain_pkg::*;
#(
  parameter int NDEV     = 3,
  parameter int CODE_W   = 12,
  parameter int CLK_NS   = 8,
  parameter int SETUP_NS = 40,
  parameter int HIGH_NS  = 40,
  parameter int LOW_NS   = 40,
  parameter int LEAD_NS  = 20,
  parameter int TAIL_NS  = 40,
  parameter int LOAD_NS  = 50,
  parameter int CNT_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NDEV*CODE_W-1:0] codes_a,
  input  logic [NDEV*CODE_W-1:0] codes_b,
  output logic                   busy,
  output logic                   done,
  output logic                   sclk,
  output logic                   sdin,
  output logic                   strobe_n
);

  localparam int LEN    = NDEV * 2 * CODE_W;
  localparam int SETUPC = ns_to_cyc(SETUP_NS, CLK_NS);
  localparam int LEADC  = max2(ns_to_cyc(LEAD_NS, CLK_NS), SETUPC);
  localparam int LOWC   = max2(ns_to_cyc(LOW_NS, CLK_NS), SETUPC);
  localparam int HIGHC  = ns_to_cyc(HIGH_NS, CLK_NS);
  localparam int TAILC  = ns_to_cyc(TAIL_NS, CLK_NS);
  localparam int LOADC  = ns_to_cyc(LOAD_NS, CLK_NS);
  localparam logic [CNT_W-1:0] LEAD_M1 = CNT_W'(LEADC - 1);
  localparam logic [CNT_W-1:0] LOW_M1  = CNT_W'(LOWC - 1);
  localparam logic [CNT_W-1:0] HIGH_M1 = CNT_W'(HIGHC - 1);
  localparam logic [CNT_W-1:0] TAIL_M1 = CNT_W'(TAILC - 1);
  localparam logic [CNT_W-1:0] LOAD_M1 = CNT_W'(LOADC - 1);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rsync_q;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_in_n = rsync_q[1];

  logic [LEN-1:0]   frame;
  logic             t_load, t_expire;
  logic [CNT_W-1:0] t_val;
  logic             s_load, s_shift, s_last;
  phase_e           st_q, st_d;
  logic             done_set;
  logic             sclk_q, stb_q, busy_q, done_q;

  frame_pack #(.NDEV(NDEV), .CODE_W(CODE_W)) u_pack (
    .codes_a (codes_a),
    .codes_b (codes_b),
    .frame   (frame)
  );

  phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_in_n),
    .load     (t_load),
    .load_val (t_val),
    .expire   (t_expire)
  );

  bit_shifter #(.LEN(LEN)) u_shift (
    .clk     (clk),
    .rst_n   (rst_in_n),
    .load    (s_load),
    .frame   (frame),
    .shift   (s_shift),
    .bit_out (sdin),
    .last    (s_last)
  );

  // Next-state process: each phase arms the timer with its length minus one.
  always_comb begin
    st_d     = st_q;
    t_load   = 1'b0;
    t_val    = '0;
    s_load   = 1'b0;
    s_shift  = 1'b0;
    done_set = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_LEAD;
        t_load = 1'b1;
        t_val  = LEAD_M1;
        s_load = 1'b1;
      end
      ST_LEAD: if (t_expire) begin
        st_d   = ST_HIGH;
        t_load = 1'b1;
        t_val  = HIGH_M1;
      end
      ST_HIGH: if (t_expire) begin
        t_load = 1'b1;
        if (s_last) begin
          st_d  = ST_TAIL;
          t_val = TAIL_M1;
        end else begin
          st_d    = ST_LOW;
          t_val   = LOW_M1;
          s_shift = 1'b1;
        end
      end
      ST_LOW: if (t_expire) begin
        st_d   = ST_HIGH;
        t_load = 1'b1;
        t_val  = HIGH_M1;
      end
      ST_TAIL: if (t_expire) begin
        st_d   = ST_LOAD;
        t_load = 1'b1;
        t_val  = LOAD_M1;
      end
      ST_LOAD: if (t_expire) begin
        st_d     = ST_IDLE;
        done_set = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Register process: pins are flops fed from the next state.
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      stb_q  <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sclk_q <= (st_d == ST_HIGH);
      stb_q  <= (st_d == ST_IDLE) || (st_d == ST_LOAD);
      busy_q <= (st_d != ST_IDLE);
      done_q <= done_set;
    end
  end

  assign sclk     = sclk_q;
  assign strobe_n = stb_q;
  assign busy     = busy_q;
  assign done     = done_q;

  // R4: the select edge only happens with the serial clock already low
  assert_sclk_low_at_select_R4: assert property (@(posedge clk) disable iff (!rst_in_n)
    $fell(strobe_n) |-> (!sclk && !$past(sclk)));

  // R5: data from the shifter is steady across the whole high phase
  assert_din_held_high_R5: assert property (@(posedge clk) disable iff (!rst_in_n)
    sclk |-> $stable(sdin));

  // R9: no clock pulse reaches the devices while they are loading
  assert_no_clock_in_load_R9: assert property (@(posedge clk) disable iff (!rst_in_n)
    strobe_n |-> !sclk);

  // R10: done closes a busy interval
  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_in_n)
    done |-> (!busy && $past(busy)));

  // R11: a new select only ever starts from idle
  assert_select_from_idle_R11: assert property (@(posedge clk) disable iff (!rst_in_n)
    $fell(strobe_n) |-> !$past(busy));

endmodule

// File: tb/sim_dacchain_host.sv
module sim_dacchain_host;

  localparam int NDEV  = 3;
  localparam int CW    = 12;
  localparam int NBITS = NDEV * 24;
  localparam int E_LEAD = 5, E_HIGH = 5, E_LOW = 5, E_TAIL = 5, E_LOAD = 7;
  localparam int E_DONE = E_LEAD + NBITS*E_HIGH + (NBITS-1)*E_LOW + E_TAIL + E_LOAD + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NDEV*CW-1:0] codes_a = '0, codes_b = '0;
  logic busy, done, sclk, sdin, strobe_n;

  always #4 clk = ~clk;

  dacchain_host u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .codes_a(codes_a), .codes_b(codes_b),
    .busy(busy), .done(done), .sclk(sclk), .sdin(sdin), .strobe_n(strobe_n)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Observer: samples on the falling edge, models the device chain.
  logic [23:0] dsr [NDEV];
  logic [CW-1:0] ra [NDEV], rb [NDEV];
  int ncyc = 0;
  logic p_sclk = 1'b0, p_stb = 1'b1, p_din = 1'b0;
  int hi_run, lo_run, rises, hi_bad, lo_bad, lead_m, tail_m, din_bad;
  int rise_cyc, done_cyc, done_cnt, fall_cnt, sel_bad, busy_bad;

  task automatic clear_stats();
    hi_run = 0; lo_run = 0; rises = 0; hi_bad = 0; lo_bad = 0;
    lead_m = -1; tail_m = -1; din_bad = 0; rise_cyc = -1; done_cyc = -1;
    done_cnt = 0; fall_cnt = 0; sel_bad = 0; busy_bad = 0;
  endtask

  always @(negedge clk) begin
    ncyc++;
    if (sclk && sdin !== p_din) din_bad++;
    if (!strobe_n && p_stb) begin
      fall_cnt++;
      if (p_sclk || sclk) sel_bad++;
    end
    if (sclk) hi_run++;
    if (!sclk && p_sclk) begin
      if (hi_run != E_HIGH) hi_bad++;
      hi_run = 0;
    end
    if (!sclk && !strobe_n) lo_run++;
    if (sclk && !p_sclk) begin
      if (rises == 0) lead_m = lo_run;
      else if (lo_run != E_LOW) lo_bad++;
      lo_run = 0;
      rises++;
      for (int k = NDEV-1; k > 0; k--) dsr[k] = {dsr[k][22:0], dsr[k-1][23]};
      dsr[0] = {dsr[0][22:0], sdin};
    end
    if (strobe_n && !p_stb) begin
      tail_m = lo_run; lo_run = 0; rise_cyc = ncyc;
      for (int k = 0; k < NDEV; k++) begin ra[k] = dsr[k][23:12]; rb[k] = dsr[k][11:0]; end
    end
    if (done) begin
      done_cnt++; done_cyc = ncyc;
      if (busy) busy_bad++;
    end
    p_sclk = sclk; p_stb = strobe_n; p_din = sdin;
  end

  task automatic run_txn(input logic [NDEV*CW-1:0] a, input logic [NDEV*CW-1:0] b,
                         input bit mid_start);
    int st_cyc, guard;
    bit busy_ok;
    clear_stats();
    @(negedge clk); #1;
    codes_a = a; codes_b = b; start = 1'b1; st_cyc = ncyc;
    guard = 0; busy_ok = 1'b1;
    while (done_cnt == 0 && guard < 3000) begin
      @(negedge clk); #1;
      guard++;
      start = 1'b0;
      if (done_cnt == 0 && !busy) busy_ok = 1'b0;
      if (mid_start && guard == 100) begin
        start = 1'b1; codes_a = ~a; codes_b = a ^ b;
      end
    end
    chk(guard < 3000, "R10", "watchdog", guard, E_DONE);
    for (int i = 0; i < 20; i++) begin @(negedge clk); #1; end
    chk(done_cyc - st_cyc == E_DONE, "R10", "done cycle", done_cyc - st_cyc, E_DONE);
    chk(busy_ok && busy_bad == 0, "R10", "busy span", busy_bad, 0);
    chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
    chk(fall_cnt == 1, "R11", "strobe falls", fall_cnt, 1);
    chk(rises == NBITS, "R2", "sclk rises", rises, NBITS);
    chk(hi_bad == 0 && lo_bad == 0, "R6", "phase widths", hi_bad + lo_bad, 0);
    chk(lead_m == E_LEAD, "R7", "lead gap", lead_m, E_LEAD);
    chk(tail_m == E_TAIL, "R8", "tail gap", tail_m, E_TAIL);
    chk(done_cyc - rise_cyc == E_LOAD, "R9", "load pulse", done_cyc - rise_cyc, E_LOAD);
    chk(din_bad == 0, "R5", "sdin in high", din_bad, 0);
    chk(sel_bad == 0, "R4", "sclk at select", sel_bad, 0);
    for (int k = 0; k < NDEV; k++)
      chk({ra[k], rb[k]} == {a[k*CW +: CW], b[k*CW +: CW]}, mid_start ? "R11" : "R3",
          "device codes", {ra[k], rb[k]}, {a[k*CW +: CW], b[k*CW +: CW]});
  endtask

  initial begin
    int seed;
    logic [NDEV*CW-1:0] ra_v, rb_v;
    seed = $urandom(32'h5EED);
    for (int k = 0; k < NDEV; k++) dsr[k] = '0;
    clear_stats();
    repeat (3) @(negedge clk);
    #1;
    chk(strobe_n && !sclk && !busy && !done, "R1", "in reset",
        {strobe_n, sclk, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    chk(strobe_n && !sclk && !busy && !done, "R1", "after reset",
        {strobe_n, sclk, busy, done}, 4'b1000);
    run_txn('0, '0, 1'b0);
    run_txn('1, '1, 1'b0);
    run_txn({NDEV*CW/2{2'b10}}, {NDEV*CW/2{2'b01}}, 1'b0);
    run_txn(36'h800_001_FFE, 36'h7FF_400_003, 1'b0);
    run_txn(36'h123_456_789, 36'hABC_DEF_024, 1'b1);
    for (int t = 0; t < 12; t++) begin
      ra_v = {$urandom, $urandom};
      rb_v = {$urandom, $urandom};
      run_txn(ra_v, rb_v, (t % 4) == 3);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL R10 global watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule